// File: doc/BRIEF.md
# Single-Bus 16-Bit Processor Datapath

This block is the data side of a small 16-bit processor. Every transfer between storage elements goes over one shared internal bus. The bus can be driven by the program counter, the ALU, the memory data register or the address mux, and each of these sources has its own gate enable. An external controller supplies every gate, load and select signal, one set per clock cycle. Each register samples the bus and captures the value on a rising edge only while its own load enable is high.

The block contains the program counter with a three-way next-value select, a memory address register fed through the address mux, a memory data register, an instruction register and an eight-entry register file. The register file has two read ports and one write port. The block also holds an ALU, an address adder and a three-bit sign/zero/positive flag register. The flags are derived from whatever is on the bus, not from the ALU. A small synchronous memory sits inside the block and completes a read or a write in one cycle.

A real tri-state bus is replaced by a one-hot gated mux. If two or more gates are enabled in the same cycle, the bus reads zero and a sticky conflict output is set until the next reset.

Top module: `bus_datapath`

## Requirements
- R1: While rst_n is low and after it is released, pc_q, ir_q, mar_q and mdr_q are zero, nzp_q is 3'b010 (zero) and bus_conflict is 0.
- R2: gate_en bit 0 selects the PC, bit 1 the ALU, bit 2 the MDR and bit 3 the address mux. With exactly one bit set, bus_q equals that source. With no bit set, bus_q is zero.
- R3: With two or more gate_en bits set, bus_q is zero and bus_conflict goes high at the next edge. It then stays high until reset.
- R4: ir_q, mar_q, mdr_q and pc_q change only on an edge where their load enable is high. ir_q and mar_q take the bus value.
- R5: When ld_pc is high, pc_sel selects the next PC value: 00 gives PC+1 (wrapping from FFFF to 0), 01 gives the address-adder sum, 10 gives the bus and 11 holds the PC.
- R6: The address-adder base is the PC (adr_base_sel=0) or SR1 (adr_base_sel=1). The offset is the sign-extended IR[5:0] (adr_ofs_sel=0) or the sign-extended IR[8:0] (adr_ofs_sel=1). The address mux passes the adder sum (mar_sel=0) or the zero-extended IR[7:0] (mar_sel=1).
- R7: With ld_reg high, the bus value is written into the register selected by dr. Reads through sr1 and sr2 are combinational.
- R8: alu_op 00 gives ADD, 01 gives AND, 10 gives the bitwise NOT of operand A and 11 passes operand A. Operand A is SR1. Operand B is SR2 when sr2_sel=0, or the sign-extended IR[4:0] when sr2_sel=1.
- R9: With ld_cc high, nzp_q takes {N,Z,P}: N (bit 2) is bus bit 15, Z (bit 1) is set when the bus is zero, and P (bit 0) is set otherwise. With ld_cc low, nzp_q holds. Exactly one of the three bits is set at all times.
- R10: With mem_en and mem_we high, mdr_q is written to memory at address mar_q[7:0]. With ld_mdr high, the MDR loads the bus (mdr_sel=0) or, in the same edge, the memory word at mar_q[7:0] (mdr_sel=1 with mem_en high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_en | input | 4 | Bus source gates: PC, ALU, MDR, address mux |
| ld_pc | input | 1 | PC load enable |
| pc_sel | input | 2 | Next-PC select |
| ld_mar | input | 1 | MAR load enable (from bus) |
| mar_sel | input | 1 | Address mux select: adder or zero-extended IR[7:0] |
| ld_mdr | input | 1 | MDR load enable |
| mdr_sel | input | 1 | MDR source: bus or memory |
| mem_en | input | 1 | Memory access enable |
| mem_we | input | 1 | Memory write (with mem_en) |
| ld_ir | input | 1 | IR load enable (from bus) |
| ld_reg | input | 1 | Register file write enable |
| dr | input | 3 | Register file write address |
| sr1 | input | 3 | First read address |
| sr2 | input | 3 | Second read address |
| sr2_sel | input | 1 | ALU operand B: SR2 or immediate |
| alu_op | input | 2 | ALU operation code |
| ld_cc | input | 1 | Flag register load enable |
| adr_base_sel | input | 1 | Address-adder base: PC or SR1 |
| adr_ofs_sel | input | 1 | Address-adder offset: 6-bit or 9-bit field |
| bus_q | output | 16 | Shared bus value |
| pc_q | output | 16 | Program counter |
| ir_q | output | 16 | Instruction register |
| mar_q | output | 16 | Memory address register |
| mdr_q | output | 16 | Memory data register |
| nzp_q | output | 3 | Flags {N,Z,P} |
| bus_conflict | output | 1 | Sticky multiple-driver error |

## Verification
The bench builds the block with the default parameters: a 16-bit word, eight registers and a 256-word memory. With a 16-bit word the PC can wrap from FFFF to 0 and bit 15 drives the N flag. With a 256-word memory, the zero-extended IR[7:0] value FE is a valid memory address, so a trap-style vector can be written and read back. The immediate fields in the IR are narrow, so negative offsets of -2 reach the address adder and bring the sum to FFFF and to 0.

// File: rtl/dp_pkg.sv
package dp_pkg;

   localparam int unsigned NGATE    = 4;
   localparam int unsigned G_PC     = 0;
   localparam int unsigned G_ALU    = 1;
   localparam int unsigned G_MDR    = 2;
   localparam int unsigned G_ADRMUX = 3;

   typedef enum logic [1:0] {
      ALU_ADD  = 2'b00,
      ALU_AND  = 2'b01,
      ALU_NOT  = 2'b10,
      ALU_PASS = 2'b11
   } alu_op_e;

   typedef enum logic [1:0] {
      PCS_INC  = 2'b00,
      PCS_ADR  = 2'b01,
      PCS_BUS  = 2'b10,
      PCS_HOLD = 2'b11
   } pc_sel_e;

endpackage

// File: rtl/dp_bus_mux.sv
module dp_bus_mux #(
   parameter int unsigned DW   = 16,
   parameter int unsigned NSRC = 4
) (
   input  logic [NSRC-1:0]    gate,
   input  logic [NSRC*DW-1:0] src_flat,
   output logic [DW-1:0]      bus,
   output logic               multi
);

   logic [DW-1:0] acc [NSRC+1];

   assign acc[0] = '0;

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
      assign acc[gi+1] = acc[gi] | (src_flat[gi*DW +: DW] & {DW{gate[gi]}});
   end

   assign multi = ($countones(gate) > 1);
   assign bus   = multi ? '0 : acc[NSRC];

endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
   parameter int unsigned DW   = 16,
   parameter int unsigned NREG = 8,
   localparam int unsigned AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [DW-1:0] rd1,
   output logic [DW-1:0] rd2
);

   logic [DW-1:0] regs [NREG];

   for (genvar ri = 0; ri < NREG; ri++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[ri] <= '0;
         else if (we && (wa == AW'(ri)))
            regs[ri] <= wd;
      end
   end

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];

   // R7: a written register reads back the written data on the next cycle
   p_rf_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wa == ra1) ##1 ($stable(ra1) && !$past(we && wa != ra1)) |-> rd1 == $past(wd))
      else $error("p_rf_write_r7");

endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
   parameter int unsigned DW    = 16,
   parameter int unsigned IMM_W = 5
) (
   input  logic [1:0]    op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b_reg,
   input  logic [DW-1:0] ir,
   input  logic          b_imm,
   output logic [DW-1:0] y
);
   import dp_pkg::*;

   logic [DW-1:0] b;
   alu_op_e       opc;

   assign b   = b_imm ? {{(DW-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]} : b_reg;
   assign opc = alu_op_e'(op);

   always_comb begin
      unique case (opc)
         ALU_ADD:  y = a + b;
         ALU_AND:  y = a & b;
         ALU_NOT:  y = ~a;
         default:  y = a;
      endcase
   end

endmodule

// File: rtl/dp_ccgen.sv
module dp_ccgen #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [DW-1:0] bus,
   output logic [2:0]    nzp
);

   logic [2:0] nzp_d;

   always_comb begin
      if (bus == '0)
         nzp_d = 3'b010;
      else if (bus[DW-1])
         nzp_d = 3'b100;
      else
         nzp_d = 3'b001;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         nzp <= 3'b010;
      else if (ld)
         nzp <= nzp_d;
   end

   p_nzp_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(nzp)) else $error("p_nzp_onehot_r9");

   p_nzp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(nzp)) else $error("p_nzp_hold_r9");

   p_nzp_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && bus[DW-1]) |=> nzp == 3'b100) else $error("p_nzp_neg_r9");

endmodule

// File: rtl/bus_datapath.sv
module bus_datapath #(
   parameter int unsigned DW        = 16,
   parameter int unsigned NREG      = 8,
   parameter int unsigned MEM_DEPTH = 256,
   parameter int unsigned IMM_W     = 5,
   parameter int unsigned OFS_S_W   = 6,
   parameter int unsigned OFS_L_W   = 9,
   parameter int unsigned TRAP_W    = 8,
   localparam int unsigned RAW      = $clog2(NREG),
   localparam int unsigned MAW      = $clog2(MEM_DEPTH),
   localparam int unsigned NG       = dp_pkg::NGATE
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NG-1:0]  gate_en,
   input  logic           ld_pc,
   input  logic [1:0]     pc_sel,
   input  logic           ld_mar,
   input  logic           mar_sel,
   input  logic           ld_mdr,
   input  logic           mdr_sel,
   input  logic           mem_en,
   input  logic           mem_we,
   input  logic           ld_ir,
   input  logic           ld_reg,
   input  logic [RAW-1:0] dr,
   input  logic [RAW-1:0] sr1,
   input  logic [RAW-1:0] sr2,
   input  logic           sr2_sel,
   input  logic [1:0]     alu_op,
   input  logic           ld_cc,
   input  logic           adr_base_sel,
   input  logic           adr_ofs_sel,
   output logic [DW-1:0]  bus_q,
   output logic [DW-1:0]  pc_q,
   output logic [DW-1:0]  ir_q,
   output logic [DW-1:0]  mar_q,
   output logic [DW-1:0]  mdr_q,
   output logic [2:0]     nzp_q,
   output logic           bus_conflict
);
   import dp_pkg::*;

   // elaboration-time parameter checks
   if (DW <= OFS_L_W || DW < TRAP_W || DW <= IMM_W || DW <= OFS_S_W) begin : g_bad_dw
      $error("bus_datapath: DW too narrow for the IR fields");
   end
   if (MAW > DW || MEM_DEPTH != (1 << MAW)) begin : g_bad_mem
      $error("bus_datapath: MEM_DEPTH must be a power of two addressable by DW");
   end
   if (NREG < 2 || NREG != (1 << RAW)) begin : g_bad_rf
      $error("bus_datapath: NREG must be a power of two >= 2");
   end

   logic [DW-1:0] rd1, rd2, alu_y, adr_sum, adr_base, adr_ofs, adrmux_y, mem_rd;
   logic [NG*DW-1:0] src_flat;
   logic             multi;
   logic [DW-1:0]    mem_arr [MEM_DEPTH];
   pc_sel_e          psel;

   // ---------------- bus ----------------
   assign src_flat[G_PC*DW     +: DW] = pc_q;
   assign src_flat[G_ALU*DW    +: DW] = alu_y;
   assign src_flat[G_MDR*DW    +: DW] = mdr_q;
   assign src_flat[G_ADRMUX*DW +: DW] = adrmux_y;

   dp_bus_mux #(.DW(DW), .NSRC(NG)) u_bus (
      .gate     (gate_en),
      .src_flat (src_flat),
      .bus      (bus_q),
      .multi    (multi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         bus_conflict <= 1'b0;
      else if (multi)
         bus_conflict <= 1'b1;
   end

   // ---------------- register file and ALU ----------------
   dp_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk (clk), .rst_n (rst_n), .we (ld_reg), .wa (dr), .wd (bus_q),
      .ra1 (sr1), .ra2 (sr2), .rd1 (rd1), .rd2 (rd2)
   );

   dp_alu #(.DW(DW), .IMM_W(IMM_W)) u_alu (
      .op (alu_op), .a (rd1), .b_reg (rd2), .ir (ir_q), .b_imm (sr2_sel), .y (alu_y)
   );

   // ---------------- address adder and address mux ----------------
   assign adr_base = adr_base_sel ? rd1 : pc_q;
   assign adr_ofs  = adr_ofs_sel
                   ? {{(DW-OFS_L_W){ir_q[OFS_L_W-1]}}, ir_q[OFS_L_W-1:0]}
                   : {{(DW-OFS_S_W){ir_q[OFS_S_W-1]}}, ir_q[OFS_S_W-1:0]};
   assign adr_sum  = adr_base + adr_ofs;
   assign adrmux_y = mar_sel ? {{(DW-TRAP_W){1'b0}}, ir_q[TRAP_W-1:0]} : adr_sum;

   // ---------------- PC ----------------
   assign psel = pc_sel_e'(pc_sel);

   always_ff @(posedge clk) begin
      if (!rst_n)
         pc_q <= '0;
      else if (ld_pc) begin
         unique case (psel)
            PCS_INC:  pc_q <= pc_q + DW'(1);
            PCS_ADR:  pc_q <= adr_sum;
            PCS_BUS:  pc_q <= bus_q;
            default:  pc_q <= pc_q;
         endcase
      end
   end

   // ---------------- IR, MAR, MDR ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ir_q  <= '0;
         mar_q <= '0;
         mdr_q <= '0;
      end else begin
         if (ld_ir)  ir_q  <= bus_q;
         if (ld_mar) mar_q <= bus_q;
         if (ld_mdr) mdr_q <= mdr_sel ? mem_rd : bus_q;
      end
   end

   // ---------------- memory ----------------
   assign mem_rd = mem_en ? mem_arr[mar_q[MAW-1:0]] : '0;

   always_ff @(posedge clk) begin
      if (mem_en && mem_we)
         mem_arr[mar_q[MAW-1:0]] <= mdr_q;
   end

   // ---------------- flags ----------------
   dp_ccgen #(.DW(DW)) u_cc (
      .clk (clk), .rst_n (rst_n), .ld (ld_cc), .bus (bus_q), .nzp (nzp_q)
   );

   // ---------------- assertions ----------------
   p_conflict_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_conflict |=> bus_conflict) else $error("p_conflict_sticky_r3");

   p_conflict_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(gate_en) > 1) |-> (bus_q == '0)) else $error("p_conflict_bus_r3");

   p_conflict_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(gate_en) > 1) |=> bus_conflict) else $error("p_conflict_set_r3");

   p_pc_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en == NG'(1 << G_PC)) |-> (bus_q == pc_q)) else $error("p_pc_gate_r2");

   p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_pc |=> $stable(pc_q)) else $error("p_pc_hold_r4");

   p_ir_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ir |=> ir_q == $past(bus_q)) else $error("p_ir_load_r4");

   p_mar_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_mar |=> $stable(mar_q)) else $error("p_mar_hold_r4");

   p_pc_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_pc && pc_sel == 2'b00) |=> pc_q == $past(pc_q) + DW'(1))
      else $error("p_pc_inc_r5");

   p_mdr_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_mdr && !mdr_sel) |=> mdr_q == $past(bus_q)) else $error("p_mdr_bus_r10");

endmodule

// File: tb/sim_bus_datapath.sv
module sim_bus_datapath;

   typedef struct packed {
      logic [3:0]  g;
      logic        ldpc;
      logic [1:0]  pcs;
      logic        ldmar;
      logic        mars;
      logic        ldmdr;
      logic        mdrs;
      logic        men;
      logic        mwe;
      logic        ldir;
      logic        ldreg;
      logic [2:0]  dr;
      logic [2:0]  s1;
      logic [2:0]  s2;
      logic        imm;
      logic [1:0]  op;
      logic        ldcc;
      logic        a1;
      logic        a2;
      logic [15:0] eb;
      logic [15:0] ep;
      logic [2:0]  ef;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t TBL [NV] = '{
      '{ldpc:1'b1, ep:16'h0001, ef:3'b010, rq:4'd5, default:'0},                           // R5 increment
      '{g:4'h1, ldpc:1'b1, ldir:1'b1, eb:16'h0001, ep:16'h0002, ef:3'b010, rq:4'd4, default:'0}, // R4 IR load
      '{g:4'h2, op:2'b10, ldreg:1'b1, dr:3'd1, ldcc:1'b1, eb:16'hFFFF, ep:16'h0002, ef:3'b100, rq:4'd8, default:'0}, // R8 NOT
      '{g:4'h2, s1:3'd1, imm:1'b1, ldreg:1'b1, dr:3'd2, ldcc:1'b1, eb:16'h0000, ep:16'h0002, ef:3'b010, rq:4'd8, default:'0}, // R8 ADD imm
      '{g:4'h2, s1:3'd1, s2:3'd1, ldreg:1'b1, dr:3'd3, ldcc:1'b1, eb:16'hFFFE, ep:16'h0002, ef:3'b100, rq:4'd7, default:'0}, // R7 two reads
      '{g:4'h2, op:2'b10, s1:3'd3, ldreg:1'b1, dr:3'd4, ldcc:1'b1, eb:16'h0001, ep:16'h0002, ef:3'b001, rq:4'd8, default:'0}, // R8 NOT
      '{g:4'h2, op:2'b01, s1:3'd3, s2:3'd4, ldcc:1'b1, eb:16'h0000, ep:16'h0002, ef:3'b010, rq:4'd9, default:'0}, // R9 zero
      '{g:4'h2, op:2'b11, s1:3'd3, ldir:1'b1, eb:16'hFFFE, ep:16'h0002, ef:3'b010, rq:4'd9, default:'0}, // R9 hold
      '{g:4'h8, mars:1'b1, ldmar:1'b1, eb:16'h00FE, ep:16'h0002, ef:3'b010, rq:4'd6, default:'0}, // R6 zext
      '{g:4'h8, a1:1'b1, s1:3'd4, ldpc:1'b1, pcs:2'b01, ldcc:1'b1, eb:16'hFFFF, ep:16'hFFFF, ef:3'b100, rq:4'd6, default:'0}, // R6 SR1+ofs6
      '{g:4'h1, ldpc:1'b1, eb:16'hFFFF, ep:16'h0000, ef:3'b100, rq:4'd5, default:'0},       // R5 wrap
      '{g:4'h1, ldpc:1'b1, pcs:2'b11, ldcc:1'b1, eb:16'h0000, ep:16'h0000, ef:3'b010, rq:4'd5, default:'0}, // R5 hold
      '{g:4'h2, s1:3'd4, s2:3'd4, ldpc:1'b1, pcs:2'b10, ldmdr:1'b1, eb:16'h0002, ep:16'h0002, ef:3'b010, rq:4'd5, default:'0}, // R5 bus
      '{g:4'h4, ldcc:1'b1, eb:16'h0002, ep:16'h0002, ef:3'b001, rq:4'd10, default:'0},     // R10 MDR gate
      '{g:4'h1, men:1'b1, mwe:1'b1, eb:16'h0002, ep:16'h0002, ef:3'b001, rq:4'd10, default:'0}, // R10 write
      '{g:4'h2, op:2'b11, s1:3'd1, ldmdr:1'b1, eb:16'hFFFF, ep:16'h0002, ef:3'b001, rq:4'd10, default:'0},
      '{ldmdr:1'b1, mdrs:1'b1, men:1'b1, eb:16'h0000, ep:16'h0002, ef:3'b001, rq:4'd10, default:'0}, // R10 read
      '{g:4'h4, eb:16'h0002, ep:16'h0002, ef:3'b001, rq:4'd10, default:'0},
      '{g:4'h8, a2:1'b1, ldmar:1'b1, eb:16'h0000, ep:16'h0002, ef:3'b001, rq:4'd6, default:'0}  // R6 PC+ofs9
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   vec_t cur = '0;
   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;

   logic [15:0] bus_q, pc_q, ir_q, mar_q, mdr_q;
   logic [2:0]  nzp_q;
   logic        bus_conflict;

   always #4 clk = ~clk;

   bus_datapath u0 (
      .clk (clk), .rst_n (rst_n), .gate_en (cur.g),
      .ld_pc (cur.ldpc), .pc_sel (cur.pcs), .ld_mar (cur.ldmar), .mar_sel (cur.mars),
      .ld_mdr (cur.ldmdr), .mdr_sel (cur.mdrs), .mem_en (cur.men), .mem_we (cur.mwe),
      .ld_ir (cur.ldir), .ld_reg (cur.ldreg), .dr (cur.dr), .sr1 (cur.s1), .sr2 (cur.s2),
      .sr2_sel (cur.imm), .alu_op (cur.op), .ld_cc (cur.ldcc),
      .adr_base_sel (cur.a1), .adr_ofs_sel (cur.a2),
      .bus_q (bus_q), .pc_q (pc_q), .ir_q (ir_q), .mar_q (mar_q), .mdr_q (mdr_q),
      .nzp_q (nzp_q), .bus_conflict (bus_conflict)
   );

   task automatic chk(input string req, input string what, input logic [15:0] act,
                      input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic reset_checks();
      chk("R1", "pc", pc_q, 16'h0);
      chk("R1", "ir", ir_q, 16'h0);
      chk("R1", "mar", mar_q, 16'h0);
      chk("R1", "mdr", mdr_q, 16'h0);
      chk("R1", "nzp", {13'b0, nzp_q}, 16'h0002);
      chk("R1", "conflict", {15'b0, bus_conflict}, 16'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      reset_checks();                                  // R1 during reset
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk("R2", "idle bus", bus_q, 16'h0);            // R2 no gate
      reset_checks();                                  // R1 after release

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         cur = TBL[i];
         #2;
         chk($sformatf("R%0d", TBL[i].rq), $sformatf("vec %0d bus", i), bus_q, TBL[i].eb);
         @(posedge clk);
         #2;
         chk($sformatf("R%0d", TBL[i].rq), $sformatf("vec %0d pc", i), pc_q, TBL[i].ep);
         chk($sformatf("R%0d", TBL[i].rq), $sformatf("vec %0d nzp", i), {13'b0, nzp_q},
             {13'b0, TBL[i].ef});
      end

      // R4: no loads while ALU drives the bus; registers keep their values
      @(negedge clk);
      cur = '0;
      cur.g = 4'h2;
      cur.op = 2'b11;
      cur.s1 = 3'd1;
      @(posedge clk);
      #2;
      chk("R4", "ir hold", ir_q, 16'hFFFE);
      chk("R4", "mar hold", mar_q, 16'h0000);
      chk("R4", "mdr hold", mdr_q, 16'h0002);
      chk("R2", "alu gate", bus_q, 16'hFFFF);

      // R3: two gates at once
      @(negedge clk);
      cur = '0;
      cur.g = 4'h3;
      #2;
      chk("R3", "conflict bus", bus_q, 16'h0);
      chk("R3", "conflict pre", {15'b0, bus_conflict}, 16'h0);
      @(posedge clk);
      #2;
      chk("R3", "conflict set", {15'b0, bus_conflict}, 16'h1);
      @(negedge clk);
      cur = '0;
      cur.g = 4'h1;
      @(posedge clk);
      #2;
      chk("R3", "conflict sticky", {15'b0, bus_conflict}, 16'h1);
      chk("R2", "pc gate after", bus_q, 16'h0002);

      // R1: reset clears everything again
      @(negedge clk);
      cur = '0;
      rst_n = 1'b0;
      @(posedge clk);
      #2;
      reset_checks();
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      chk("R3", "conflict after reset", {15'b0, bus_conflict}, 16'h0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule